// File: doc/BRIEF.md
# Wormhole Router Input Port

This block is one input port of a five-port router in a two-dimensional mesh. Flits arrive from a neighbouring router or from the local processing unit, each tagged with a virtual-channel number. The port keeps one small FIFO per virtual channel. At the FIFO front it works out the output direction of each packet by dimension-order routing, with X resolved before Y. It holds that direction for the rest of the wormhole packet and offers one flit per cycle to the crossbar.

The upstream side is credit-style. `vc_full[v]` tells the sender that channel `v` has no room left, and the sender must not offer a non-idle flit to a full channel. The downstream side is valid/ready with one ready bit per virtual channel. `sw_ready[v]` says whether the crossbar can take a flit of channel `v` this cycle. The port raises `sw_valid` only for a channel whose ready bit is high, so every cycle with `sw_valid` high is a completed transfer. A channel whose ready bit is low holds its flits and does not stop the other channels. Eligible channels are served in round-robin order.

Flit kind encoding on `in_kind` and `sw_kind`: 0 = idle, 1 = head, 2 = body, 3 = tail. The head flit's data carries the destination X coordinate in bits [1:0] and the Y coordinate in bits [3:2]. The direction code on `sw_dir` is 0 = local, 1 = north, 2 = east, 3 = south, 4 = west. The router's own coordinates are the parameters `LOC_X` and `LOC_Y`.

Top module: `wh_inport`

## Requirements
- R1: While reset is asserted, and after its release until a flit has been stored, `vc_full` is all zero and `sw_valid` is low, whatever `sw_ready` is.
- R2: A flit whose kind is idle (code 0) is never stored and never appears on the switch output.
- R3: Each virtual channel stores up to `BUF_DEPTH` (4) flits and delivers them in arrival order. `vc_full[v]` is high exactly when channel `v` holds 4 flits. A non-idle flit is never offered to a full channel.
- R4: For a head flit (code 1), `sw_dir` is east (2) when data[1:0] > `LOC_X` and west (4) when it is smaller. Otherwise it is south (3) when data[3:2] > `LOC_Y` and north (1) when it is smaller. Otherwise it is local (0).
- R5: Body (code 2) and tail (code 3) flits leave with the direction computed from their packet's head, whatever their own data bits are.
- R6: `sw_valid` is high only when some channel holds a flit and has its `sw_ready` bit high. Each such cycle moves exactly one flit out of the channel named by `sw_vc`.
- R7: After reset the first grant goes to channel 0. From then on each grant goes to the first eligible channel after the one granted last, so two channels that are both eligible alternate cycle by cycle.
- R8: A channel whose `sw_ready` bit is low keeps its flits and does not delay the flits of another channel whose ready bit is high.
- R9: When a tail leaves, the saved direction of that channel is cleared. A head that follows directly on the same channel is routed from its own destination.
- R10: A flit written at a clock edge can be granted in the next cycle. A write and a read on the same channel in one cycle both take effect and leave its occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming flit is present |
| in_vc | input | VC_W | Virtual channel of the incoming flit |
| in_kind | input | 2 | Kind of the incoming flit (0 idle, 1 head, 2 body, 3 tail) |
| in_data | input | DATA_W | Payload of the incoming flit |
| vc_full | output | NUM_VC | Per-channel full flag, used as credit by the sender |
| sw_ready | input | NUM_VC | Per-channel acceptance by the crossbar |
| sw_valid | output | 1 | A flit is transferred to the crossbar this cycle |
| sw_vc | output | VC_W | Channel of the outgoing flit |
| sw_kind | output | 2 | Kind of the outgoing flit |
| sw_data | output | DATA_W | Payload of the outgoing flit |
| sw_dir | output | 3 | Output direction of the outgoing flit's packet |

## Verification
Two functions share a cycle here. One channel can be written and read in the same cycle. A head's direction can also be latched while the previous packet's tail on the same channel has only just cleared it. The bench provokes both by pushing a back-to-back stream of packets into a channel whose ready bit is held high, so each cycle's write lands while that channel's front flit is being granted. A cycle-by-cycle model in the bench judges the run: it holds per-channel queues, the saved directions and the last grant. Every cycle, occupancy, order, kind, data, direction and `vc_full` are compared against that model.

// File: rtl/wh_pkg.sv
`timescale 1ns/1ps
package wh_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'd0,
    FK_HEAD = 2'd1,
    FK_BODY = 2'd2,
    FK_TAIL = 2'd3
  } flit_kind_e;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  localparam int KIND_W = 2;
  localparam int DIR_W  = 3;
endpackage

// File: rtl/wh_vc_fifo.sv
`timescale 1ns/1ps
module wh_vc_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] used;
  logic             do_wr, do_rd;

  assign full    = (used == CNT_W'(DEPTH));
  assign empty   = (used == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      unique case ({do_wr, do_rd})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/wh_xy_route.sv
`timescale 1ns/1ps
module wh_xy_route import wh_pkg::*; #(
  parameter int COORD_W = 2,
  parameter int LOC_X   = 1,
  parameter int LOC_Y   = 1
) (
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [DIR_W-1:0]   dir
);
  localparam logic [COORD_W-1:0] HERE_X = COORD_W'(LOC_X);
  localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(LOC_Y);

  always_comb begin
    if (dst_x > HERE_X)      dir = DIR_EAST;
    else if (dst_x < HERE_X) dir = DIR_WEST;
    else if (dst_y > HERE_Y) dir = DIR_SOUTH;
    else if (dst_y < HERE_Y) dir = DIR_NORTH;
    else                     dir = DIR_LOCAL;
  end
endmodule

// File: rtl/wh_rr_arb.sv
`timescale 1ns/1ps
module wh_rr_arb #(
  parameter int N = 2,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  logic [IDX_W-1:0] last;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      automatic int idx = (int'(last) + k) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        gnt_idx  = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last <= IDX_W'(N - 1);
    else if (any) last <= gnt_idx;
  end
endmodule

// File: rtl/wh_inport.sv
`timescale 1ns/1ps
module wh_inport import wh_pkg::*; #(
  parameter int NUM_VC    = 2,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 4,
  parameter int COORD_W   = 2,
  parameter int LOC_X     = 1,
  parameter int LOC_Y     = 1,
  localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VC_W-1:0]   in_vc,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_data,
  output logic [NUM_VC-1:0] vc_full,
  input  logic [NUM_VC-1:0] sw_ready,
  output logic              sw_valid,
  output logic [VC_W-1:0]   sw_vc,
  output logic [1:0]        sw_kind,
  output logic [DATA_W-1:0] sw_data,
  output logic [2:0]        sw_dir
);
  localparam int ENT_W = KIND_W + DATA_W;

  logic [NUM_VC-1:0] vc_empty, vc_req, vc_gnt;
  logic [ENT_W-1:0]  vc_front [NUM_VC];
  logic [DIR_W-1:0]  vc_dir   [NUM_VC];
  logic [VC_W-1:0]   gnt_idx;
  logic              gnt_any;
  logic              in_real;

  assign in_real = in_valid && (in_kind != FK_IDLE);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic              wr;
    logic [KIND_W-1:0] f_kind;
    logic [DATA_W-1:0] f_data;
    logic [DIR_W-1:0]  head_dir;
    logic [DIR_W-1:0]  held_dir;

    assign wr = in_real && (in_vc == VC_W'(v));

    wh_vc_fifo #(.WIDTH(ENT_W), .DEPTH(BUF_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr),
      .wr_data ({in_kind, in_data}),
      .rd_en   (vc_gnt[v]),
      .rd_data (vc_front[v]),
      .empty   (vc_empty[v]),
      .full    (vc_full[v])
    );

    assign f_kind = vc_front[v][ENT_W-1 -: KIND_W];
    assign f_data = vc_front[v][DATA_W-1:0];

    wh_xy_route #(.COORD_W(COORD_W), .LOC_X(LOC_X), .LOC_Y(LOC_Y)) u_route (
      .dst_x (f_data[COORD_W-1:0]),
      .dst_y (f_data[2*COORD_W-1:COORD_W]),
      .dir   (head_dir)
    );

    // Wormhole: the head decides, the rest of the packet follows.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_dir <= DIR_LOCAL;
      else if (vc_gnt[v]) begin
        if (f_kind == FK_HEAD)      held_dir <= head_dir;
        else if (f_kind == FK_TAIL) held_dir <= DIR_LOCAL;
      end
    end

    assign vc_dir[v] = (f_kind == FK_HEAD) ? head_dir : held_dir;
    assign vc_req[v] = !vc_empty[v] && sw_ready[v];
  end

  wh_rr_arb #(.N(NUM_VC)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (vc_req),
    .gnt     (vc_gnt),
    .gnt_idx (gnt_idx),
    .any     (gnt_any)
  );

  always_comb begin
    sw_valid = gnt_any;
    sw_vc    = gnt_idx;
    sw_kind  = '0;
    sw_data  = '0;
    sw_dir   = '0;
    if (gnt_any) begin
      sw_kind = vc_front[gnt_idx][ENT_W-1 -: KIND_W];
      sw_data = vc_front[gnt_idx][DATA_W-1:0];
      sw_dir  = vc_dir[gnt_idx];
    end
  end
endmodule

// File: rtl/wh_inport_chk.sv
`timescale 1ns/1ps
module wh_inport_chk #(
  parameter int NUM_VC = 2,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [VC_W-1:0]   in_vc,
  input logic [1:0]        in_kind,
  input logic [NUM_VC-1:0] vc_full,
  input logic [NUM_VC-1:0] sw_ready,
  input logic              sw_valid,
  input logic [VC_W-1:0]   sw_vc,
  input logic [1:0]        sw_kind,
  input logic [2:0]        sw_dir
);
  logic [2:0] trk_dir [NUM_VC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VC; v++) trk_dir[v] <= 3'd0;
    end else if (sw_valid && sw_kind == 2'd1) begin
      trk_dir[sw_vc] <= sw_dir;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind != 2'd0) |-> !vc_full[in_vc]); // R3
  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |-> sw_ready[sw_vc]); // R6
  AST_NO_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |-> (sw_kind != 2'd0)); // R2
  AST_WORM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_kind != 2'd1) |-> (sw_dir == trk_dir[sw_vc])); // R5

  for (genvar g = 0; g < NUM_VC; g++) begin : g_full
    AST_FULL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vc_full[g]) |-> $past(in_valid && in_kind != 2'd0 && in_vc == VC_W'(g))); // R3
    AST_FULL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vc_full[g]) |-> $past(sw_valid && sw_vc == VC_W'(g))); // R3
  end
endmodule

bind wh_inport wh_inport_chk #(.NUM_VC(NUM_VC)) u_chk (.*);

// File: tb/wh_inport_test.sv
`timescale 1ns/1ps
module wh_inport_test;
  localparam int LX = 1;
  localparam int LY = 1;
  localparam logic [1:0] K_IDLE = 2'd0, K_HEAD = 2'd1, K_BODY = 2'd2, K_TAIL = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [0:0] in_vc;
  logic [1:0] in_kind;
  logic [7:0] in_data;
  logic [1:0] vc_full;
  logic [1:0] sw_ready;
  logic       sw_valid;
  logic [0:0] sw_vc;
  logic [1:0] sw_kind;
  logic [7:0] sw_data;
  logic [2:0] sw_dir;

  always #2 clk = ~clk;

  wh_inport #(.NUM_VC(2), .DATA_W(8), .BUF_DEPTH(4), .COORD_W(2), .LOC_X(LX), .LOC_Y(LY)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_kind(in_kind),
    .in_data(in_data), .vc_full(vc_full), .sw_ready(sw_ready), .sw_valid(sw_valid),
    .sw_vc(sw_vc), .sw_kind(sw_kind), .sw_data(sw_data), .sw_dir(sw_dir)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] mk [2][4];
  logic [7:0] md [2][4];
  int         mcnt [2];
  logic [2:0] msv [2];
  int         mlast;

  function automatic logic [2:0] xy(input logic [7:0] d);
    int x = int'(d[1:0]);
    int y = int'(d[3:2]);
    if (x > LX) return 3'd2;
    if (x < LX) return 3'd4;
    if (y > LY) return 3'd3;
    if (y < LY) return 3'd1;
    return 3'd0;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare against the model, then advance it.
  task automatic step(input bit v, input int vc, input logic [1:0] k, input logic [7:0] d,
                      input logic [1:0] rdy, input string tag);
    bit ev = 0;
    int evc = 0;
    logic [2:0] edir;
    in_valid = v; in_vc = vc[0]; in_kind = k; in_data = d; sw_ready = rdy;
    #1;
    for (int s = 1; s <= 2; s++) begin
      int idx = (mlast + s) % 2;
      if (!ev && mcnt[idx] > 0 && rdy[idx]) begin ev = 1; evc = idx; end
    end
    chk(sw_valid == ev, {tag, " R6 R7 valid"}, int'(sw_valid), int'(ev));
    if (ev && sw_valid) begin
      edir = (mk[evc][0] == K_HEAD) ? xy(md[evc][0]) : msv[evc];
      chk(int'(sw_vc) == evc, {tag, " R7 R8 vc"}, int'(sw_vc), evc);
      chk(sw_kind == mk[evc][0], {tag, " R3 kind"}, int'(sw_kind), int'(mk[evc][0]));
      chk(sw_data == md[evc][0], {tag, " R3 data"}, int'(sw_data), int'(md[evc][0]));
      chk(sw_dir == edir, {tag, " R4 R5 R9 dir"}, int'(sw_dir), int'(edir));
    end
    for (int c = 0; c < 2; c++)
      chk(vc_full[c] == (mcnt[c] == 4), {tag, " R3 full flag"}, int'(vc_full[c]), int'(mcnt[c] == 4));
    @(posedge clk);
    if (v && k != K_IDLE) chk(mcnt[vc] < 4, {tag, " R3 write into full VC"}, mcnt[vc], 3);
    if (ev) begin
      if (mk[evc][0] == K_HEAD)      msv[evc] = xy(md[evc][0]);
      else if (mk[evc][0] == K_TAIL) msv[evc] = 3'd0;
      for (int j = 0; j < 3; j++) begin mk[evc][j] = mk[evc][j+1]; md[evc][j] = md[evc][j+1]; end
      mcnt[evc]--;
      mlast = evc;
    end
    if (v && k != K_IDLE && mcnt[vc] < 4) begin
      mk[vc][mcnt[vc]] = k; md[vc][mcnt[vc]] = d; mcnt[vc]++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [1:0] rdy, input string tag);
    step(0, 0, K_IDLE, 8'h00, rdy, tag);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_vc = 0; in_kind = 0; in_data = 0; sw_ready = 2'b11;
    mlast = 1;
    for (int c = 0; c < 2; c++) begin mcnt[c] = 0; msv[c] = 3'd0; end
    repeat (3) @(negedge clk);
    #1;
    chk(vc_full == 2'b00, "R1 full during reset", int'(vc_full), 0);
    chk(sw_valid == 1'b0, "R1 valid during reset", int'(sw_valid), 0);
    @(negedge clk);
    rst_n = 1;
    idle(2'b11, "R1");
    idle(2'b11, "R1");

    // R2: idle flits on both channels leave nothing behind
    step(1, 0, K_IDLE, 8'h55, 2'b11, "R2");
    step(1, 1, K_IDLE, 8'hAA, 2'b11, "R2");
    idle(2'b11, "R2");

    // R4 R5: sweep every destination, alternating channels
    for (int dst = 0; dst < 16; dst++) begin
      int vc = dst % 2;
      logic [1:0] r = (vc == 0) ? 2'b01 : 2'b10;
      step(1, vc, K_HEAD, 8'hA0 | 8'(dst), 2'b00, "R4");
      step(1, vc, K_BODY, 8'(dst) ^ 8'h0F, 2'b00, "R5");
      step(1, vc, K_TAIL, 8'(15 - dst), 2'b00, "R5");
      repeat (4) idle(r, "R4");
    end

    // R3: fill channel 1 to its depth, hold, then drain
    for (int i = 0; i < 4; i++) step(1, 1, (i == 0) ? K_HEAD : K_BODY, 8'h30 + 8'(i), 2'b00, "R3");
    idle(2'b00, "R3");
    idle(2'b01, "R3");
    repeat (4) idle(2'b10, "R3");
    step(1, 1, K_TAIL, 8'h3F, 2'b10, "R3");
    idle(2'b10, "R3");

    // R8: channel 1 blocked while channel 0 drains
    step(1, 0, K_HEAD, 8'h0B, 2'b00, "R8");
    step(1, 0, K_BODY, 8'h01, 2'b00, "R8");
    step(1, 0, K_BODY, 8'h02, 2'b00, "R8");
    step(1, 0, K_TAIL, 8'h03, 2'b00, "R8");
    step(1, 1, K_HEAD, 8'h04, 2'b00, "R8");
    step(1, 1, K_BODY, 8'h0C, 2'b00, "R8");
    step(1, 1, K_BODY, 8'h0D, 2'b00, "R8");
    step(1, 1, K_TAIL, 8'h0E, 2'b00, "R8");
    repeat (5) idle(2'b01, "R8");
    repeat (5) idle(2'b11, "R8");

    // R7: both channels eligible, grants alternate
    step(1, 0, K_HEAD, 8'h09, 2'b00, "R7");
    step(1, 1, K_HEAD, 8'h01, 2'b00, "R7");
    for (int i = 0; i < 2; i++) begin
      step(1, 0, K_BODY, 8'h60 + 8'(i), 2'b00, "R7");
      step(1, 1, K_BODY, 8'h70 + 8'(i), 2'b00, "R7");
    end
    step(1, 0, K_TAIL, 8'h6F, 2'b00, "R7");
    step(1, 1, K_TAIL, 8'h7F, 2'b00, "R7");
    repeat (9) idle(2'b11, "R7");

    // R9 R10: back-to-back packets written while the same channel drains
    step(1, 0, K_HEAD, 8'h05, 2'b01, "R10");
    step(1, 0, K_BODY, 8'h0F, 2'b01, "R10");
    step(1, 0, K_TAIL, 8'h00, 2'b01, "R9");
    step(1, 0, K_HEAD, 8'h02, 2'b01, "R9");
    step(1, 0, K_BODY, 8'h05, 2'b01, "R9");
    step(1, 0, K_TAIL, 8'h05, 2'b01, "R9");
    step(1, 1, K_HEAD, 8'h06, 2'b11, "R10");
    step(1, 0, K_HEAD, 8'h08, 2'b11, "R10");
    step(1, 1, K_TAIL, 8'h11, 2'b11, "R10");
    step(1, 0, K_TAIL, 8'h22, 2'b11, "R10");
    repeat (4) idle(2'b11, "R10");
    idle(2'b11, "R2");

    done = 1;
    summary();
    $finish;
  end
endmodule